// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for every beat of an SDRAM read or write burst. A start pulse loads a starting column together with the burst mode fields: the length code, the ordering type, the write-single mode bit and the access direction. From the next cycle on, the block presents one column per beat. An advance strobe steps to the next beat. A last-beat flag marks the final beat, and after that beat is advanced the burst ends.

Finite bursts of 2, 4 or 8 stay inside an aligned block of that size and wrap within it. The beats follow either sequential order (start plus beat index, modulo the length) or interleaved order (start XOR beat index). A full-page burst walks the whole row in sequential order, wrapping at the end of the row, until a terminate input ends it. Command generation and data movement belong to the surrounding controller.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst_ni` is low and after its release, `valid_o` and `last_o` are 0 until a start pulse is seen.
- R2: A start pulse sampled at a clock edge makes `valid_o` 1 from that edge on, with `col_o` equal to the sampled `col_i` as beat 0.
- R3: Length code `bl_code_i` is decoded as 0→1, 1→2, 2→4, 3→8 and 7→full page; the reserved codes 4, 5 and 6 give a single-beat burst.
- R4: With `ilv_i`=0 and a finite length L, beat i has low log2(L) column bits equal to (start + i) mod L, and the upper bits equal those of the start column.
- R5: With `ilv_i`=1 and a finite length L, beat i has low log2(L) column bits equal to the start's low bits XOR i, and the upper bits unchanged.
- R6: A full-page burst gives beat i the column (start + i) mod 2^COL_W and never ends on its own. `term_i` raises `last_o` in the same cycle and ends the burst at that edge. `term_i` has no effect on finite bursts.
- R7: Code 7 together with `ilv_i`=1 is treated as a single-beat burst.
- R8: With `wr_single_i`=1 and `is_wr_i`=1, the burst is a single beat whatever the code. With `is_wr_i`=0, or with `wr_single_i`=0, the programmed length applies.
- R9: In a cycle where `adv_i` is 0 (and no start or terminate arrives), the beat does not change, and neither do `col_o` nor `valid_o`.
- R10: `last_o` is 1 exactly on beat L-1 of a finite burst. An advance on that beat makes `valid_o` 0 at the next edge.
- R11: A start pulse during a burst discards it and begins the new burst at beat 0 with the new fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst; the fields below are sampled with it |
| col_i | input | COL_W | Starting column |
| bl_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| wr_single_i | input | 1 | Write burst mode: 1 = writes are single-location |
| is_wr_i | input | 1 | 1 = the burst is a write |
| adv_i | input | 1 | Step to the next beat |
| term_i | input | 1 | Burst terminate; acts only on full-page bursts |
| col_o | output | COL_W | Column for the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | The current beat is the final one |

## Verification
Random bursts draw the start column, all eight length codes, both orderings, and both settings of the write mode and direction. They run under an advance strobe that is high about three cycles in four. A sequential/interleaved mix-up shows at odd starting offsets. A wrong block mask shows on starts near the block's top. Stalls on the advance strobe separate the advance from free-running counting. Random terminates on finite bursts catch a terminate that leaks into them. Directed cases cover a full-page burst that crosses column 1023 back to 0, a terminate on the first full-page beat, interleaved with full page, and a restart during a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    BL_1    = 3'd0,
    BL_2    = 3'd1,
    BL_4    = 3'd2,
    BL_8    = 3'd3,
    BL_PAGE = 3'd7
  } bl_code_e;
endpackage

// File: rtl/bs_len_decode.sv
module bs_len_decode
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [2:0]       code_i,
  input  logic             ilv_i,
  input  logic             wr_single_i,
  input  logic             is_wr_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);
  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    case (code_i)
      BL_2:    mask_o = COL_W'(1);
      BL_4:    mask_o = COL_W'(3);
      BL_8:    mask_o = COL_W'(7);
      BL_PAGE: begin
        // interleaved page is not defined: fall back to single beat
        full_o = ~ilv_i;
        mask_o = ilv_i ? '0 : '1;
      end
      default: mask_o = '0;
    endcase
    if (wr_single_i && is_wr_i) begin
      mask_o = '0;
      full_o = 1'b0;
    end
  end
endmodule

// File: rtl/bs_beat_cnt.sv
module bs_beat_cnt #(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  output logic [COL_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (start_i) cnt_o <= '0;
    else if (step_i)  cnt_o <= cnt_o + COL_W'(1);
  end
endmodule

// File: rtl/bs_col_gen.sv
module bs_col_gen #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  input  logic [COL_W-1:0] cnt_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_sum;
  assign seq_sum = base_i + cnt_i;
  // beat index never exceeds the mask, so XOR leaves the upper bits alone
  assign col_o = ilv_i ? (base_i ^ cnt_i)
                       : ((base_i & ~mask_i) | (seq_sum & mask_i));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             ilv_i,
  input  logic             wr_single_i,
  input  logic             is_wr_i,
  input  logic             adv_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] mask_d, mask_q, base_q, cnt;
  logic             full_d, full_q, ilv_q, valid_q, done;

  bs_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i(bl_code_i), .ilv_i(ilv_i), .wr_single_i(wr_single_i),
    .is_wr_i(is_wr_i), .mask_o(mask_d), .full_o(full_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (start_i) begin
      base_q <= col_i;
      mask_q <= mask_d;
      full_q <= full_d;
      ilv_q  <= ilv_i;
    end
  end

  assign last_o = valid_q & (full_q ? term_i : (cnt == mask_q));
  assign done   = valid_q & ((adv_i & last_o) | (full_q & term_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= 1'b0;
    else if (start_i) valid_q <= 1'b1;
    else if (done)    valid_q <= 1'b0;
  end

  bs_beat_cnt #(.COL_W(COL_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .step_i(valid_q & adv_i & ~done), .cnt_o(cnt)
  );

  bs_col_gen #(.COL_W(COL_W)) u_col (
    .base_i(base_q), .mask_i(mask_q), .ilv_i(ilv_q), .cnt_i(cnt), .col_o(col_o)
  );

  assign valid_o = valid_q;
endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
  parameter int COL_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] col_i,
  input logic [2:0]       bl_code_i,
  input logic             adv_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  logic [2:0] code_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      code_q <= 3'd0;
    else if (start_i) code_q <= bl_code_i;
  end

  a_r1_rise_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(start_i));
  a_r2_start_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  a_r2_start_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> col_o == $past(col_i));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i && !adv_i && !term_i) |=> (valid_o && $stable(col_o)));
  a_r10_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && adv_i && last_o && !start_i) |=> !valid_o);
  a_r10_last_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
  a_r4_block_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && adv_i && !last_o && !start_i && code_q <= 3'd3)
      |=> $stable(col_o[COL_W-1:3]));
endmodule

bind burst_col_seq bs_checker #(.COL_W(COL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .col_i(col_i),
  .bl_code_i(bl_code_i), .adv_i(adv_i), .term_i(term_i),
  .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
);

// File: tb/tb_burst_col_seq.sv
`timescale 1ns/1ps
module tb_burst_col_seq;
  localparam int COL_W = 10;
  localparam int PAGE  = 1 << COL_W;

  logic             clk_i = 1'b0, rst_ni = 1'b0;
  logic             start_i = 0, ilv_i = 0, wr_single_i = 0, is_wr_i = 0;
  logic             adv_i = 0, term_i = 0;
  logic [COL_W-1:0] col_i = '0;
  logic [2:0]       bl_code_i = '0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;
  int               errors = 0, checks = 0, cycles = 0;

  always #2 clk_i = ~clk_i;

  burst_col_seq #(.COL_W(COL_W)) dut (.*);

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      summary();
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // 0 means full page
  function automatic int exp_len(int code, bit ilv, bit wrs, bit iswr);
    if (wrs && iswr) return 1;
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return ilv ? 1 : 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(int base, int len, bit ilv, int i);
    if (len == 0) return (base + i) % PAGE;
    if (ilv) return base ^ i;
    return (base & ~(len - 1)) | ((base + i) % len);
  endfunction

  function automatic string mode_tag(int code, bit ilv, bit wrs, bit iswr, int len);
    if (wrs && iswr) return "R8";
    if (code == 7 && ilv) return "R7";
    if (code >= 4 && code <= 6) return "R3";
    if (len == 0) return "R6";
    if (ilv) return "R5";
    return "R4";
  endfunction

  task automatic launch(int col, int code, bit ilv, bit wrs, bit iswr);
    @(negedge clk_i);
    start_i = 1; col_i = COL_W'(col); bl_code_i = 3'(code);
    ilv_i = ilv; wr_single_i = wrs; is_wr_i = iswr; adv_i = 0; term_i = 0;
    @(negedge clk_i);
    start_i = 0;
  endtask

  // nfull: beat index on which the terminate is sent for full-page bursts
  task automatic run_burst(int col, int code, bit ilv, bit wrs, bit iswr, int nfull);
    int len = exp_len(code, ilv, wrs, iswr);
    string tag = mode_tag(code, ilv, wrs, iswr, len);
    int i = 0;
    bit prev_adv = 1;
    bit fin = 0;
    launch(col, code, ilv, wrs, iswr);
    while (!fin) begin
      bit adv = ($urandom % 4) != 0;
      bit trm = 0;
      string t;
      if (len == 0) begin
        if (i == nfull) adv = 1;
        trm = (i == nfull);
      end else trm = ($urandom % 3) == 0;   // must be ignored
      adv_i = adv; term_i = trm;
      #1;
      t = (i == 0) ? "R2" : (!prev_adv ? "R9" : tag);
      chk({t, " valid"}, valid_o, 1);
      chk({t, " col"}, col_o, exp_col(col, len, ilv, i));
      chk({(len == 0) ? "R6" : "R10", " last"}, last_o,
          (len == 0) ? trm : (i == len - 1));
      if (adv && ((len == 0) ? trm : (i == len - 1))) fin = 1;
      if (adv) i++;
      prev_adv = adv;
      @(negedge clk_i);
    end
    adv_i = 0; term_i = 0;
    #1;
    chk("R10 ended", valid_o, 0);
    chk("R10 no last", last_o, 0);
  endtask

  initial begin
    void'($urandom(32'd7177));
    #1;
    chk("R1 reset valid", valid_o, 0);
    chk("R1 reset last", last_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i); #1;
    chk("R1 idle valid", valid_o, 0);
    chk("R1 idle last", last_o, 0);

    // directed corners
    run_burst(10'h0FE, 3, 0, 0, 0, 0);          // R4 wrap near block top
    run_burst(10'h0FE, 3, 1, 0, 0, 0);          // R5
    run_burst(10'h3F9, 2, 1, 0, 1, 0);          // R8 wrs=0: full length on write
    run_burst(10'h155, 3, 0, 1, 1, 0);          // R8 single write
    run_burst(10'h155, 3, 0, 1, 0, 0);          // R8 read keeps length
    run_burst(10'h233, 5, 0, 0, 0, 0);          // R3 reserved
    run_burst(10'h233, 7, 1, 0, 0, 0);          // R7
    run_burst(10'h3F0, 7, 0, 0, 0, 40);         // R6 crosses 1023 -> 0
    run_burst(10'h012, 7, 0, 0, 0, 0);          // R6 terminate on beat 0
    run_burst(10'h001, 7, 0, 0, 0, PAGE + 5);   // R6 full wrap of the row

    // R11 restart mid-burst
    launch(10'h0A3, 3, 0, 0, 0);
    adv_i = 1;
    repeat (2) @(negedge clk_i);
    start_i = 1; col_i = 10'h2C6; bl_code_i = 3'd2; ilv_i = 1; adv_i = 0;
    @(negedge clk_i);
    start_i = 0; adv_i = 1;
    #1;
    chk("R11 restart col", col_o, 10'h2C6);
    chk("R11 restart last", last_o, 0);
    @(negedge clk_i); #1;
    chk("R11 beat1 col", col_o, 10'h2C7);
    @(negedge clk_i); #1;
    chk("R11 beat2 col", col_o, 10'h2C4);
    @(negedge clk_i); #1;
    chk("R11 beat3 col", col_o, 10'h2C5);
    chk("R11 beat3 last", last_o, 1);
    @(negedge clk_i); adv_i = 0; #1;
    chk("R11 ended", valid_o, 0);

    for (int n = 0; n < 400; n++)
      run_burst($urandom % PAGE, $urandom % 8, $urandom % 2,
                ($urandom % 4) == 0, $urandom % 2, $urandom % 24);
    summary();
  end
endmodule